// File: doc/BRIEF.md
# 4x4 Inverse Integer Transform and Reconstruction

This block rebuilds one 4x4 block of 8-bit pixels from sixteen signed 16-bit
dequantized coefficients and a matching 4x4 block of prediction pixels. In the
full mode it applies the separable inverse integer transform: first along each
row, then along each column. It rounds each result, scales it down by 64, adds
it to the prediction pixel with signed 16-bit saturation and clamps the sum to
0..255.

A second mode takes only the DC coefficient. It rounds and scales that value
once and adds it to all sixteen prediction pixels. The block is a three-stage
pipeline and accepts a new block on every cycle.

Element (r, c) of every 4x4 array sits at flat index r*4+c. Coefficient k
occupies `coef_in[k*16 +: 16]`. Pixel k occupies `pred_in[k*8 +: 8]` and
`recon_out[k*8 +: 8]`.

Top module: `idct4_recon`

## Requirements
- R1: While reset is held and after its release, before any block is issued, `done` is 0 and `recon_out` is all zeros.
- R2: A block presented with `start` high at a rising edge produces a one-cycle `done` pulse exactly three rising edges later, with its result on `recon_out`.
- R3: One 1-D pass over inputs y0..y3 computes e0=y0+y2, e1=y0-y2, e2=(y1>>>1)-y3, e3=y1+(y3>>>1). It then outputs z0=e0+e3, z1=e1+e2, z2=e1-e2, z3=e0-e3, using arithmetic shifts.
- R4: In full mode (`dc_only`=0) the 1-D pass is first applied to each coefficient row (indices r*4+0..3), then to each column of those results. The output at (r, c) comes from the column pass of column c, position r.
- R5: Each transformed sample z becomes s=(z+32)>>>6, with the +32 wrapping at 16 bits.
- R6: All intermediate sums of both passes are kept to 16 bits with two's-complement wrap-around.
- R7: The reconstructed pixel is the signed 16-bit saturating sum of s and the zero-extended prediction pixel, clamped to 0..255. With all coefficients zero, the output equals the prediction.
- R8: In DC-only mode (`dc_only`=1) every pixel receives (coef0+32)>>>6 added to its own prediction, with the same saturation and clamping. Coefficients 1..15 have no effect.
- R9: Blocks issued on consecutive cycles each produce their own result, in issue order, on consecutive cycles.
- R10: While `done` is low, `recon_out` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Block present on the inputs this cycle |
| dc_only | input | 1 | 1 selects the DC-only path, 0 the full transform |
| coef_in | input | 256 | Sixteen signed 16-bit coefficients, index r*4+c |
| pred_in | input | 128 | Sixteen unsigned 8-bit prediction pixels |
| done | output | 1 | One-cycle pulse marking a valid result |
| recon_out | output | 128 | Sixteen reconstructed 8-bit pixels |

## Verification
The checker watches four properties on every cycle: the three-cycle latency of `done`, the output holding steady between pulses, and exact pass-through of the prediction for an all-zero block in either mode. Whether the butterfly arithmetic, the row-then-column order, the 16-bit wrap, the rounding and the clamping give the right pixel values can only be shown by the bench. It compares each result against an independent model over random blocks, extreme-valued blocks, DC blocks with nonzero AC terms, and back-to-back issue.

// File: rtl/idct4_pkg.sv
package idct4_pkg;

    localparam int COEF_W  = 16;
    localparam int PIX_W   = 8;
    localparam int SIDE    = 4;
    localparam int NPIX    = SIDE * SIDE;
    localparam int RND_ADD = 32;
    localparam int RND_SH  = 6;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef coef_t [SIDE-1:0]         quad_t;
    typedef coef_t [NPIX-1:0]         cblk_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef pix_t [NPIX-1:0]          pblk_t;

    typedef struct packed {
        logic  valid;
        logic  dc_only;
        coef_t dc;
        cblk_t data;
        pblk_t pred;
    } stage_t;

    // One 1-D inverse butterfly; every sum wraps at COEF_W bits.
    function automatic quad_t inv_bfly(input quad_t y);
        coef_t a0, a1, a2, a3;
        coef_t e0, e1, e2, e3;
        quad_t z;
        a0 = y[0];
        a1 = y[1];
        a2 = y[2];
        a3 = y[3];
        e0 = a0 + a2;
        e1 = a0 - a2;
        e2 = (a1 >>> 1) - a3;
        e3 = a1 + (a3 >>> 1);
        z[0] = e0 + e3;
        z[1] = e1 + e2;
        z[2] = e1 - e2;
        z[3] = e0 - e3;
        return z;
    endfunction

    // Round, scale, saturating add to prediction, clamp to pixel range.
    function automatic pix_t rebuild(input coef_t z, input pix_t p);
        coef_t                   biased;
        coef_t                   scaled;
        logic signed [COEF_W:0]  wide;
        coef_t                   sat;
        biased = z + coef_t'(RND_ADD);
        scaled = biased >>> RND_SH;
        wide   = {scaled[COEF_W-1], scaled} + {{(COEF_W+1-PIX_W){1'b0}}, p};
        if (wide > $signed({2'b00, {(COEF_W-1){1'b1}}}))
            sat = {1'b0, {(COEF_W-1){1'b1}}};
        else if (wide < $signed({2'b11, {(COEF_W-1){1'b0}}}))
            sat = {1'b1, {(COEF_W-1){1'b0}}};
        else
            sat = wide[COEF_W-1:0];
        if (sat < 0)
            return '0;
        else if (sat > coef_t'(PIX_MAX))
            return pix_t'(PIX_MAX);
        else
            return sat[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/idct4_row_pass.sv
module idct4_row_pass
    import idct4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t in_s,
    output stage_t out_s
);

    stage_t st_d, st_q;
    cblk_t  row_res;

    generate
        for (genvar r = 0; r < SIDE; r++) begin : g_row
            quad_t q_in, q_out;
            always_comb begin
                for (int k = 0; k < SIDE; k++)
                    q_in[k] = in_s.data[r*SIDE + k];
                q_out = inv_bfly(q_in);
            end
            for (genvar k = 0; k < SIDE; k++) begin : g_el
                assign row_res[r*SIDE + k] = q_out[k];
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_s.valid;
        if (in_s.valid) begin
            st_d.dc_only = in_s.dc_only;
            st_d.dc      = in_s.data[0];
            st_d.data    = row_res;
            st_d.pred    = in_s.pred;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_s = st_q;

endmodule

// File: rtl/idct4_col_pass.sv
module idct4_col_pass
    import idct4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t in_s,
    output stage_t out_s
);

    stage_t st_d, st_q;
    cblk_t  col_res;

    generate
        for (genvar c = 0; c < SIDE; c++) begin : g_col
            quad_t q_in, q_out;
            always_comb begin
                for (int k = 0; k < SIDE; k++)
                    q_in[k] = in_s.data[k*SIDE + c];
                q_out = inv_bfly(q_in);
            end
            for (genvar k = 0; k < SIDE; k++) begin : g_el
                assign col_res[k*SIDE + c] = q_out[k];
            end
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_s.valid;
        if (in_s.valid) begin
            st_d.dc_only = in_s.dc_only;
            st_d.dc      = in_s.dc;
            st_d.data    = col_res;
            st_d.pred    = in_s.pred;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_s = st_q;

endmodule

// File: rtl/idct4_recon_stage.sv
module idct4_recon_stage
    import idct4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t in_s,
    output logic   done,
    output pblk_t  pix
);

    typedef struct packed {
        logic  done;
        pblk_t pix;
    } out_t;

    out_t  o_d, o_q;
    pblk_t built;

    generate
        for (genvar i = 0; i < NPIX; i++) begin : g_pix
            coef_t src;
            assign src      = in_s.dc_only ? in_s.dc : in_s.data[i];
            assign built[i] = rebuild(src, in_s.pred[i]);
        end
    endgenerate

    always_comb begin
        o_d      = o_q;
        o_d.done = in_s.valid;
        if (in_s.valid)
            o_d.pix = built;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign done = o_q.done;
    assign pix  = o_q.pix;

endmodule

// File: rtl/idct4_recon.sv
module idct4_recon
    import idct4_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    dc_only,
    input  logic [NPIX*COEF_W-1:0]  coef_in,
    input  logic [NPIX*PIX_W-1:0]   pred_in,
    output logic                    done,
    output logic [NPIX*PIX_W-1:0]   recon_out
);

    stage_t s0, s1, s2;
    pblk_t  pix_blk;

    always_comb begin
        s0         = '0;
        s0.valid   = start;
        s0.dc_only = dc_only;
        s0.dc      = coef_in[COEF_W-1:0];
        s0.data    = cblk_t'(coef_in);
        s0.pred    = pblk_t'(pred_in);
    end

    idct4_row_pass u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .in_s  (s0),
        .out_s (s1)
    );

    idct4_col_pass u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .in_s  (s1),
        .out_s (s2)
    );

    idct4_recon_stage u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .in_s  (s2),
        .done  (done),
        .pix   (pix_blk)
    );

    assign recon_out = pix_blk;

endmodule

// File: rtl/idct4_recon_checker.sv
module idct4_recon_checker
    import idct4_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    dc_only,
    input logic [NPIX*COEF_W-1:0]  coef_in,
    input logic [NPIX*PIX_W-1:0]   pred_in,
    input logic                    done,
    input logic [NPIX*PIX_W-1:0]   recon_out
);

    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done == $past(start, 3));

    p_zero_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && !dc_only && (coef_in == '0), 3) |-> recon_out == $past(pred_in, 3));

    p_dc_zero_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && dc_only && (coef_in[COEF_W-1:0] == '0), 3) |-> recon_out == $past(pred_in, 3));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(recon_out));

endmodule

bind idct4_recon idct4_recon_checker u_idct4_recon_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dc_only   (dc_only),
    .coef_in   (coef_in),
    .pred_in   (pred_in),
    .done      (done),
    .recon_out (recon_out)
);

// File: tb/idct4_recon_bench.sv
module idct4_recon_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dc_only = 1'b0;
    logic [255:0] coef_in = '0;
    logic [127:0] pred_in = '0;
    logic         done;
    logic [127:0] recon_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [127:0] exp_q[$];
    int           iss_q[$];
    string        tag_q[$];
    logic [127:0] last_exp = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idct4_recon u_idct4_recon (
        .clk(clk), .rst_n(rst_n), .start(start), .dc_only(dc_only),
        .coef_in(coef_in), .pred_in(pred_in), .done(done), .recon_out(recon_out)
    );

    // R3: reference butterfly, 16-bit wrap (R6)
    function automatic void bf(input shortint a0, a1, a2, a3,
                               output shortint z0, z1, z2, z3);
        shortint e0, e1, e2, e3;
        e0 = shortint'(a0 + a2);
        e1 = shortint'(a0 - a2);
        e2 = shortint'((a1 >>> 1) - a3);
        e3 = shortint'(a1 + (a3 >>> 1));
        z0 = shortint'(e0 + e3);
        z1 = shortint'(e1 + e2);
        z2 = shortint'(e1 - e2);
        z3 = shortint'(e0 - e3);
    endfunction

    // R5, R7: round, saturate, clamp
    function automatic logic [7:0] pix_of(input shortint z, input logic [7:0] p);
        shortint t;
        int s, sum;
        t = shortint'(z + 16'sd32);
        s = int'(t >>> 6);
        sum = s + int'(p);
        if (sum > 32767) sum = 32767;
        if (sum < -32768) sum = -32768;
        if (sum < 0) return 8'd0;
        if (sum > 255) return 8'd255;
        return sum[7:0];
    endfunction

    // R4, R8: full model
    function automatic logic [127:0] model(input logic [255:0] c,
                                           input logic [127:0] p, input bit dc);
        shortint m[16];
        shortint rr[16];
        shortint cc[16];
        logic [127:0] r;
        for (int k = 0; k < 16; k++) m[k] = shortint'(c[k*16 +: 16]);
        for (int i = 0; i < 4; i++)
            bf(m[i*4], m[i*4+1], m[i*4+2], m[i*4+3],
               rr[i*4], rr[i*4+1], rr[i*4+2], rr[i*4+3]);
        for (int j = 0; j < 4; j++)
            bf(rr[j], rr[4+j], rr[8+j], rr[12+j],
               cc[j], cc[4+j], cc[8+j], cc[12+j]);
        for (int k = 0; k < 16; k++)
            r[k*8 +: 8] = pix_of(dc ? m[0] : cc[k], p[k*8 +: 8]);
        return r;
    endfunction

    task automatic issue(input logic [255:0] c, input logic [127:0] p,
                         input bit dc, input string tag);
        @(negedge clk);
        start   = 1'b1;
        dc_only = dc;
        coef_in = c;
        pred_in = p;
        exp_q.push_back(model(c, p, dc));
        iss_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: done with nothing pending, actual=1 expected=0");
            end else begin
                logic [127:0] e;
                int    ic;
                string tg;
                e  = exp_q.pop_front();
                ic = iss_q.pop_front();
                tg = tag_q.pop_front();
                last_exp = e;
                n_cmp++;
                if (recon_out !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h", tg, recon_out, e);
                end
                n_cmp++;
                if (cyc - ic != 3) begin
                    n_bad++;
                    $display("FAIL R2: latency actual=%0d expected=3", cyc - ic);
                end
            end
        end else if (rst_n && !done && cyc > 8) begin
            if (recon_out !== last_exp) begin
                n_cmp++; n_bad++;
                $display("FAIL R10: hold actual=%h expected=%h", recon_out, last_exp);
            end
        end
    end

    function automatic logic [255:0] rnd_coef(input int mag);
        logic [255:0] c;
        for (int k = 0; k < 16; k++)
            c[k*16 +: 16] = 16'(int'($urandom_range(0, 2*mag)) - mag);
        return c;
    endfunction

    function automatic logic [127:0] rnd_pred();
        logic [127:0] p;
        for (int k = 0; k < 16; k++) p[k*8 +: 8] = 8'($urandom_range(0, 255));
        return p;
    endfunction

    initial begin : watchdog
        #(5 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        logic [255:0] c;
        logic [127:0] p;
        repeat (4) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (done !== 1'b0 || recon_out !== '0) begin
            n_bad++;
            $display("FAIL R1: actual done=%b recon=%h expected done=0 recon=0", done, recon_out);
        end
        rst_n = 1'b1;
        idle(3);
        n_cmp++;
        if (done !== 1'b0 || recon_out !== '0) begin
            n_bad++;
            $display("FAIL R1: after release done=%b recon=%h expected 0/0", done, recon_out);
        end

        // R7: zero coefficients pass the prediction through
        issue('0, rnd_pred(), 1'b0, "R7 zero block");
        idle(4);
        // R4/R5: single DC coefficient in full mode
        c = '0; c[15:0] = 16'sd64;
        issue(c, {16{8'd100}}, 1'b0, "R5 full dc64");
        idle(4);
        // R3/R4: lone AC terms at asymmetric positions
        c = '0; c[1*16 +: 16] = 16'sd640; c[6*16 +: 16] = -16'sd320;
        issue(c, {16{8'd128}}, 1'b0, "R4 asym AC");
        idle(4);
        c = '0; c[3*16 +: 16] = 16'sd900; c[12*16 +: 16] = 16'sd450;
        issue(c, {16{8'd128}}, 1'b0, "R3 odd terms");
        idle(4);
        // R7: clamp high and low
        c = '0; c[15:0] = 16'sd2000;
        issue(c, {16{8'd250}}, 1'b1, "R7 clamp high");
        idle(4);
        c = '0; c[15:0] = -16'sd2000;
        issue(c, {16{8'd5}}, 1'b1, "R7 clamp low");
        idle(4);
        // R6: wrap of intermediates
        c = '0; for (int k = 0; k < 16; k++) c[k*16 +: 16] = 16'sh7fff;
        issue(c, rnd_pred(), 1'b0, "R6 wrap max");
        idle(4);
        c = '0; c[0 +: 16] = 16'sh7ff0; c[2*16 +: 16] = 16'sh7ff0; c[8*16 +: 16] = 16'sh8000;
        issue(c, rnd_pred(), 1'b0, "R6 wrap mix");
        idle(4);
        // R8: DC-only ignores AC coefficients
        c = rnd_coef(30000); c[15:0] = 16'sd200;
        issue(c, rnd_pred(), 1'b1, "R8 dc ignore AC");
        idle(4);
        c = rnd_coef(30000); c[15:0] = -16'sd97;
        issue(c, rnd_pred(), 1'b1, "R8 dc negative");
        idle(4);
        // R9: back-to-back mixed modes
        for (int i = 0; i < 12; i++)
            issue(rnd_coef(i < 6 ? 1500 : 32000), rnd_pred(), i[0], "R9 back-to-back");
        idle(5);
        // R4/R5: random blocks with gaps
        for (int i = 0; i < 40; i++) begin
            issue(rnd_coef(4000), rnd_pred(), (i % 5) == 0, "R4 random");
            idle(1 + (i % 3));
        end
        idle(6);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: pending actual=%0d expected=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule